// File: doc/BRIEF.md
# Receive Frame Filter and Descriptor Writer

This block takes received Ethernet frames as a byte stream, decides from the first six bytes whether the destination address is wanted, and copies wanted frames into memory. Memory is described by a chain of descriptors. Each descriptor holds a buffer pointer, a size word with an "empty" flag, and a pointer to the next descriptor. A completed frame writes its length into the size word, which clears the empty flag, and the block then moves on to the next descriptor.

Software sets the station address, the length limit, the per-class broadcast and multicast policy, and the first descriptor through a small register port. It reads back a received-frame counter and status flags from the same port. If the current descriptor is still owned by software, the frame is dropped, an overflow flag latches and the receive channel turns itself off. Software can acknowledge frames one at a time by writing to the status register.

Top module: `rx_frame_store`

## Requirements
- R1: A frame is taken into memory only if the receive enable (CTRL bit 2) and the channel enable (DMA bit 0) are both set when its first byte arrives. Any other frame is consumed with no memory access.
- R2: A frame longer than MAXLEN[15:0] is not completed. Bytes beyond the limit are not written, the size word is left untouched and the counter does not move. A frame exactly at the limit is stored. MAXLEN resets to 0x600.
- R3: A destination of all ones is broadcast. A destination whose first octet has bit 0 set is multicast. Any other destination passes only if all six octets equal the station address. Octets 1 to 4 are STN_A[31:24], [23:16], [15:8] and [7:0], and octets 5 and 6 are STN_B[31:24] and [23:16].
- R4: Broadcast uses bit 9 and multicast uses bit 8 of both DROP and KEEP. A class passes when its KEEP bit is set, and otherwise passes only if its DROP bit is clear. KEEP resets to 0x300 and DROP resets to 0.
- R5: A frame that ends before its sixth byte is dropped with no memory access.
- R6: A descriptor at address D has the buffer address at D+0, the size word at D+4 (bit 31 = empty) and the next descriptor at D+8. Byte i of a stored frame at buffer B is written once, to word address (B+i) with the low two bits cleared, with strobe 1<<((B+i) mod 4) and the byte repeated in all four lanes. Then the size word is rewritten with the length in bits [10:0] and all other bits zero, and D+8 becomes the current descriptor.
- R7: Each stored frame increments an 8-bit counter in STAT[23:16] and sets STAT bit 0. Writing STAT with bit 0 set decrements the counter, and bit 0 clears only when the counter reaches zero.
- R8: If the current size word has bit 31 clear, the frame is dropped with no write, STAT bit 2 (overflow) sets, and DMA bit 0 clears. Writing STAT with bit 2 set clears the overflow flag.
- R9: Writing DMA with bit 0 set reloads the current descriptor from DESC. DESC stores its value with bits [1:0] forced to zero.
- R10: The address decision is taken when the sixth byte arrives. A rejected frame is drained to its last byte with no memory access.
- R11: The register word indices are CTRL 0, MAXLEN 1, STN_A 2, STN_B 3, DROP 4, KEEP 5, DMA 6, DESC 7 and STAT 8. All other registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Block takes the byte at this edge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte strobes for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The assertions assume a memory that accepts every request at once and returns read data exactly one cycle after a read. They also assume that software does not touch the length limit or re-enable the channel while a frame is in flight. The bench memory model answers with that fixed one-cycle latency and never stalls. The bench writes registers only after each frame has fully drained and the expected-write queue is empty, so the length bound checked at completion and the single-step counter moves hold on every cycle.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;
  localparam int WORD_W = 32;
  localparam int HDR_N  = 6;
  localparam int SIZE_W = 11;

  localparam logic [3:0] RA_CTRL   = 4'd0;
  localparam logic [3:0] RA_MAXLEN = 4'd1;
  localparam logic [3:0] RA_STN_A  = 4'd2;
  localparam logic [3:0] RA_STN_B  = 4'd3;
  localparam logic [3:0] RA_DROP   = 4'd4;
  localparam logic [3:0] RA_KEEP   = 4'd5;
  localparam logic [3:0] RA_DMA    = 4'd6;
  localparam logic [3:0] RA_DESC   = 4'd7;
  localparam logic [3:0] RA_STAT   = 4'd8;

  localparam int B_RXEN  = 2;
  localparam int B_DMAEN = 0;
  localparam int B_BCAST = 9;
  localparam int B_MCAST = 8;
  localparam int B_RCVD  = 0;
  localparam int B_OVF   = 2;
  localparam int B_EMPTY = 31;
  localparam int CNT_LSB = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_DRAIN, S_RD_SZ, S_CAP_SZ,
    S_CAP_BUF, S_CAP_NXT, S_FLUSH, S_STREAM, S_WR_SZ
  } rx_state_e;

  typedef logic [HDR_N-1:0][7:0] mac_t;
endpackage

// File: rtl/rxfs_filter.sv
module rxfs_filter
  import rxfs_pkg::*;
(
  input  mac_t dest_i,
  input  mac_t station_i,
  input  logic drop_bc_i,
  input  logic drop_mc_i,
  input  logic keep_bc_i,
  input  logic keep_mc_i,
  output logic pass_o
);
  logic is_bc;
  logic is_mc;
  logic is_me;

  always_comb begin
    is_bc = &dest_i;
    is_mc = dest_i[0][0];
    is_me = (dest_i == station_i);
    if (is_bc)      pass_o = keep_bc_i | ~drop_bc_i;
    else if (is_mc) pass_o = keep_mc_i | ~drop_mc_i;
    else            pass_o = is_me;
  end
endmodule

// File: rtl/rxfs_regs.sv
module rxfs_regs
  import rxfs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              done_i,
  input  logic              ovf_i,
  output logic              rx_on_o,
  output logic [LEN_W-1:0]  max_len_o,
  output mac_t              station_o,
  output logic              drop_bc_o,
  output logic              drop_mc_o,
  output logic              keep_bc_o,
  output logic              keep_mc_o,
  output logic              reload_o,
  output logic [ADDR_W-1:0] desc_base_o
);
  localparam logic [LEN_W-1:0] MAXLEN_RST = LEN_W'(16'h0600);

  logic              rx_en_q, rx_en_d;
  logic [LEN_W-1:0]  maxlen_q, maxlen_d;
  logic [31:0]       stn_a_q, stn_a_d;
  logic [15:0]       stn_b_q, stn_b_d;
  logic [1:0]        drop_q, drop_d;
  logic [1:0]        keep_q, keep_d;
  logic              dma_q, dma_d;
  logic [ADDR_W-3:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rcvd_q, rcvd_d;
  logic              ovf_q, ovf_d;

  logic wr_ctrl, wr_max, wr_sa, wr_sb, wr_drop, wr_keep, wr_dma, wr_desc, wr_stat;
  logic dec;

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    wr_max  = reg_we && (reg_addr == RA_MAXLEN);
    wr_sa   = reg_we && (reg_addr == RA_STN_A);
    wr_sb   = reg_we && (reg_addr == RA_STN_B);
    wr_drop = reg_we && (reg_addr == RA_DROP);
    wr_keep = reg_we && (reg_addr == RA_KEEP);
    wr_dma  = reg_we && (reg_addr == RA_DMA);
    wr_desc = reg_we && (reg_addr == RA_DESC);
    wr_stat = reg_we && (reg_addr == RA_STAT);

    rx_en_d  = wr_ctrl ? reg_wdata[B_RXEN] : rx_en_q;
    maxlen_d = wr_max  ? reg_wdata[LEN_W-1:0] : maxlen_q;
    stn_a_d  = wr_sa   ? reg_wdata : stn_a_q;
    stn_b_d  = wr_sb   ? reg_wdata[31:16] : stn_b_q;
    drop_d   = wr_drop ? {reg_wdata[B_BCAST], reg_wdata[B_MCAST]} : drop_q;
    keep_d   = wr_keep ? {reg_wdata[B_BCAST], reg_wdata[B_MCAST]} : keep_q;
    base_d   = wr_desc ? reg_wdata[ADDR_W-1:2] : base_q;

    if (ovf_i)       dma_d = 1'b0;
    else if (wr_dma) dma_d = reg_wdata[B_DMAEN];
    else             dma_d = dma_q;

    dec   = wr_stat && reg_wdata[B_RCVD];
    cnt_d = cnt_q + CNT_W'(done_i) - CNT_W'(dec);
    if (done_i)                         rcvd_d = 1'b1;
    else if (dec && cnt_d == '0)        rcvd_d = 1'b0;
    else                                rcvd_d = rcvd_q;

    if (ovf_i)                          ovf_d = 1'b1;
    else if (wr_stat && reg_wdata[B_OVF]) ovf_d = 1'b0;
    else                                ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q  <= 1'b0;
      maxlen_q <= MAXLEN_RST;
      stn_a_q  <= '0;
      stn_b_q  <= '0;
      drop_q   <= 2'b00;
      keep_q   <= 2'b11;
      dma_q    <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      rcvd_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      rx_en_q  <= rx_en_d;
      maxlen_q <= maxlen_d;
      stn_a_q  <= stn_a_d;
      stn_b_q  <= stn_b_d;
      drop_q   <= drop_d;
      keep_q   <= keep_d;
      dma_q    <= dma_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      rcvd_q   <= rcvd_d;
      ovf_q    <= ovf_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:   reg_rdata[B_RXEN] = rx_en_q;
      RA_MAXLEN: reg_rdata[LEN_W-1:0] = maxlen_q;
      RA_STN_A:  reg_rdata = stn_a_q;
      RA_STN_B:  reg_rdata[31:16] = stn_b_q;
      RA_DROP:   begin reg_rdata[B_BCAST] = drop_q[1]; reg_rdata[B_MCAST] = drop_q[0]; end
      RA_KEEP:   begin reg_rdata[B_BCAST] = keep_q[1]; reg_rdata[B_MCAST] = keep_q[0]; end
      RA_DMA:    reg_rdata[B_DMAEN] = dma_q;
      RA_DESC:   reg_rdata[ADDR_W-1:0] = {base_q, 2'b00};
      RA_STAT: begin
        reg_rdata[CNT_LSB +: CNT_W] = cnt_q;
        reg_rdata[B_OVF]  = ovf_q;
        reg_rdata[B_RCVD] = rcvd_q;
      end
      default:   reg_rdata = '0;
    endcase
  end

  for (genvar k = 0; k < 4; k++) begin : g_stn_a
    assign station_o[k] = stn_a_q[31-8*k -: 8];
  end
  assign station_o[4] = stn_b_q[15:8];
  assign station_o[5] = stn_b_q[7:0];

  assign rx_on_o     = rx_en_q & dma_q;
  assign max_len_o   = maxlen_q;
  assign drop_bc_o   = drop_q[1];
  assign drop_mc_o   = drop_q[0];
  assign keep_bc_o   = keep_q[1];
  assign keep_mc_o   = keep_q[0];
  assign reload_o    = wr_dma & reg_wdata[B_DMAEN];
  assign desc_base_o = {base_q, 2'b00};

  // R8: overflow latching leaves the channel switched off
  p_dma_off_after_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> !dma_q);
  // R7: the frame counter moves by at most one per cycle
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) ||
                        (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  // R7: a completed frame always shows as received
  p_rcvd_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> rcvd_q);
endmodule

// File: rtl/rxfs_engine.sv
module rxfs_engine
  import rxfs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              rx_on_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              reload_i,
  input  logic [ADDR_W-1:0] desc_base_i,
  output mac_t              dest_o,
  input  logic              pass_i,
  output logic              done_o,
  output logic              ovf_o
);
  localparam int LW    = LEN_W + 1;
  localparam int IDX_W = $clog2(HDR_N);

  rx_state_e         state_q, state_d;
  mac_t              hdr_q, hdr_d;
  logic [LW-1:0]     len_q, len_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] buf_q, buf_d;
  logic [ADDR_W-1:0] nxt_q, nxt_d;
  logic              last_q, last_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  logic              fire;
  logic              hdr_fits;
  logic              byte_wr;
  logic [7:0]        wr_byte;
  logic [ADDR_W-1:0] wr_ba;
  logic [LW-1:0]     lim;

  always_comb begin
    for (int k = 0; k < HDR_N; k++) begin
      dest_o[k] = (k == HDR_N-1) ? in_data_i : hdr_q[k];
    end
  end

  always_comb begin
    state_d = state_q;
    hdr_d   = hdr_q;
    len_d   = len_q;
    buf_d   = buf_q;
    nxt_d   = nxt_q;
    last_d  = last_q;
    idx_d   = idx_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = 4'h0;
    mem_wdata_o = '0;
    byte_wr = 1'b0;
    wr_byte = 8'h00;
    wr_ba   = '0;
    done_o  = 1'b0;
    ovf_o   = 1'b0;
    lim      = {1'b0, max_len_i};
    hdr_fits = LW'(HDR_N) <= lim;
    in_ready_o = (state_q == S_IDLE) || (state_q == S_HDR) ||
                 (state_q == S_DRAIN) || (state_q == S_STREAM);
    fire = in_valid_i && in_ready_o;

    case (state_q)
      S_IDLE: if (fire) begin
        if (!rx_on_i) begin
          state_d = in_last_i ? S_IDLE : S_DRAIN;
        end else begin
          hdr_d[0] = in_data_i;
          len_d    = LW'(1);
          state_d  = in_last_i ? S_IDLE : S_HDR;
        end
      end
      S_HDR: if (fire) begin
        hdr_d[len_q[IDX_W-1:0]] = in_data_i;
        len_d = len_q + LW'(1);
        if (len_q == LW'(HDR_N-1)) begin
          if (pass_i && hdr_fits) begin
            state_d = S_RD_SZ;
            last_d  = in_last_i;
          end else begin
            state_d = in_last_i ? S_IDLE : S_DRAIN;
          end
        end else if (in_last_i) begin
          state_d = S_IDLE;
        end
      end
      S_DRAIN: if (fire && in_last_i) state_d = S_IDLE;
      S_RD_SZ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + ADDR_W'(4);
        mem_be_o   = 4'hF;
        state_d    = S_CAP_SZ;
      end
      S_CAP_SZ: begin
        if (mem_rdata_i[B_EMPTY]) begin
          mem_req_o  = 1'b1;
          mem_addr_o = cur_q;
          mem_be_o   = 4'hF;
          state_d    = S_CAP_BUF;
        end else begin
          ovf_o   = 1'b1;
          state_d = last_q ? S_IDLE : S_DRAIN;
        end
      end
      S_CAP_BUF: begin
        buf_d      = mem_rdata_i[ADDR_W-1:0];
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + ADDR_W'(8);
        mem_be_o   = 4'hF;
        state_d    = S_CAP_NXT;
      end
      S_CAP_NXT: begin
        nxt_d   = mem_rdata_i[ADDR_W-1:0];
        idx_d   = '0;
        state_d = S_FLUSH;
      end
      S_FLUSH: begin
        byte_wr = 1'b1;
        wr_byte = hdr_q[idx_q];
        wr_ba   = buf_q + ADDR_W'(idx_q);
        idx_d   = idx_q + IDX_W'(1);
        if (idx_q == IDX_W'(HDR_N-1)) state_d = last_q ? S_WR_SZ : S_STREAM;
      end
      S_STREAM: if (fire) begin
        if (len_q >= lim) begin
          state_d = in_last_i ? S_IDLE : S_DRAIN;
        end else begin
          byte_wr = 1'b1;
          wr_byte = in_data_i;
          wr_ba   = buf_q + ADDR_W'(len_q);
          len_d   = len_q + LW'(1);
          if (in_last_i) state_d = S_WR_SZ;
        end
      end
      S_WR_SZ: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + ADDR_W'(4);
        mem_be_o    = 4'hF;
        mem_wdata_o = {{(WORD_W-SIZE_W){1'b0}}, len_q[SIZE_W-1:0]};
        done_o      = 1'b1;
        state_d     = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase

    if (byte_wr) begin
      mem_req_o   = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = {wr_ba[ADDR_W-1:2], 2'b00};
      mem_be_o    = 4'b0001 << wr_ba[1:0];
      mem_wdata_o = {4{wr_byte}};
    end

    if (reload_i)                cur_d = desc_base_i;
    else if (state_q == S_WR_SZ) cur_d = nxt_q;
    else                         cur_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      hdr_q   <= '0;
      len_q   <= '0;
      cur_q   <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      last_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      len_q   <= len_d;
      cur_q   <= cur_d;
      buf_q   <= buf_d;
      nxt_q   <= nxt_d;
      last_q  <= last_d;
      idx_q   <= idx_d;
    end
  end

  // R10: a frame being drained never touches memory
  p_drain_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DRAIN) |-> !mem_req_o);
  // R6: a rewritten size word always hands the descriptor back (empty clear)
  p_size_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_be_o == 4'hF) |-> !mem_wdata_o[B_EMPTY]);
  // R2: no frame completes beyond the length limit
  p_len_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_q <= {1'b0, max_len_i}));
  // R8: overflow and completion never coincide
  p_ovf_not_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> !done_o && !mem_we_o);
endmodule

// File: rtl/rx_frame_store.sv
module rx_frame_store
  import rxfs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic              rx_on, reload, done, ovf, pass;
  logic              drop_bc, drop_mc, keep_bc, keep_mc;
  logic [LEN_W-1:0]  max_len;
  logic [ADDR_W-1:0] desc_base;
  mac_t              station, dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  rxfs_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_i(done), .ovf_i(ovf),
    .rx_on_o(rx_on), .max_len_o(max_len), .station_o(station),
    .drop_bc_o(drop_bc), .drop_mc_o(drop_mc), .keep_bc_o(keep_bc),
    .keep_mc_o(keep_mc), .reload_o(reload), .desc_base_o(desc_base)
  );

  rxfs_filter u_filter (
    .dest_i(dest), .station_i(station), .drop_bc_i(drop_bc), .drop_mc_i(drop_mc),
    .keep_bc_i(keep_bc), .keep_mc_i(keep_mc), .pass_o(pass)
  );

  rxfs_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst_n(rst_n_s), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .in_ready_o(in_ready), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .rx_on_i(rx_on),
    .max_len_i(max_len), .reload_i(reload), .desc_base_i(desc_base),
    .dest_o(dest), .pass_i(pass), .done_o(done), .ovf_o(ovf)
  );
endmodule

// File: tb/test_rx_frame_store.sv
`timescale 1ns/1ps
module test_rx_frame_store;
  typedef struct packed {
    logic [31:0] a;
    logic [3:0]  be;
    logic [31:0] d;
  } wr_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last, in_ready;
  logic [7:0]  in_data;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int total = 0;
  int bad   = 0;
  string  tag = "R6";
  logic [7:0] mem [logic [31:0]];
  logic [7:0] frm [$];
  wr_t        exp_q [$];

  localparam logic [47:0] ME    = 48'h021122334455;
  localparam logic [47:0] OTHER = 48'h021122334456;
  localparam logic [47:0] BC    = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MC    = 48'h01005E000001;

  always #10 clk = ~clk;

  rx_frame_store i_rx_frame_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] rdb(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rdb(a+3), rdb(a+2), rdb(a+1), rdb(a)};
  endfunction
  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    for (int k = 0; k < 4; k++) mem[a+k] = d[8*k +: 8];
  endtask

  // memory model: one-cycle read latency, writes by strobe
  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= rd32(mem_addr);
    if (mem_req && mem_we)
      for (int k = 0; k < 4; k++) if (mem_be[k]) mem[mem_addr+k] = mem_wdata[8*k +: 8];
  end

  // monitor: compares every memory write against the scoreboard queue
  always begin
    @(negedge clk);
    #5;
    if (rst_n && mem_req && mem_we) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s unexpected write addr=%h be=%h data=%h expected none",
                 tag, mem_addr, mem_be, mem_wdata);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        if (mem_addr !== e.a || mem_be !== e.be || mem_wdata !== e.d) begin
          bad++;
          $display("FAIL %s write actual=%h/%h/%h expected=%h/%h/%h",
                   tag, mem_addr, mem_be, mem_wdata, e.a, e.be, e.d);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic mk_frame(input logic [47:0] dst, input int n);
    frm.delete();
    for (int k = 0; k < 6 && k < n; k++) frm.push_back(dst[47-8*k -: 8]);
    for (int i = 6; i < n; i++) frm.push_back(8'(i*7 + 3));
  endtask

  task automatic send_frm();
    @(negedge clk);
    for (int i = 0; i < frm.size(); i++) begin
      in_valid = 1'b1;
      in_data  = frm[i];
      in_last  = (i == frm.size()-1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  // driver side of the scoreboard: expected writes of one frame
  task automatic expect_frm(input logic [31:0] d, input logic [31:0] b,
                            input int nwr, input bit complete);
    for (int i = 0; i < nwr; i++) begin
      logic [31:0] a;
      a = b + i;
      exp_q.push_back({a & ~32'h3, 4'b0001 << a[1:0], {4{frm[i]}}});
    end
    if (complete) exp_q.push_back({d + 32'd4, 4'hF, 32'(frm.size())});
  endtask

  task automatic settle(input string req);
    repeat (14) @(negedge clk);
    check(req, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic set_desc(input logic [31:0] d, input logic [31:0] b,
                          input logic [31:0] sz, input logic [31:0] nx);
    wr32(d, b); wr32(d+4, sz); wr32(d+8, nx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    reg_we = 1'b0; reg_addr = 4'd0; reg_wdata = '0; mem_rdata = '0;
    set_desc(32'h100, 32'h1000, 32'h8000_0000, 32'h110);
    set_desc(32'h110, 32'h1100, 32'h8000_0000, 32'h120);
    set_desc(32'h120, 32'h1200, 32'h8000_0000, 32'h130);
    set_desc(32'h130, 32'h1300, 32'h8000_0000, 32'h140);
    set_desc(32'h140, 32'h1400, 32'h8000_0000, 32'h150);
    set_desc(32'h150, 32'h1500, 32'h0000_0000, 32'h160);
    set_desc(32'h200, 32'h2000, 32'h8000_0000, 32'h210);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 / R2 / R4 reset values
    reg_rd(4'd1, r); check("R2 maxlen reset", r, 32'h600);
    reg_rd(4'd5, r); check("R4 keep reset", r, 32'h300);
    reg_rd(4'd8, r); check("R11 status reset", r, 32'h0);
    reg_rd(4'd6, r); check("R11 dma reset", r, 32'h0);

    reg_wr(4'd2, 32'h0211_2233);
    reg_wr(4'd3, 32'h4455_0000);
    reg_wr(4'd0, 32'h4);
    reg_wr(4'd7, 32'h103);
    reg_rd(4'd7, r); check("R9 desc low bits", r, 32'h100);
    reg_wr(4'd6, 32'h1);

    // R3 unicast exact match, R6 layout
    tag = "R3"; mk_frame(ME, 10); expect_frm(32'h100, 32'h1000, 10, 1);
    send_frm(); settle("R3 unicast match");
    check("R6 size word", rd32(32'h104), 32'd10);
    reg_rd(4'd8, r); check("R7 count one", r, 32'h0001_0001);

    // R10 mismatch is drained
    tag = "R10"; mk_frame(OTHER, 9);
    send_frm(); settle("R10 mismatch");
    reg_rd(4'd8, r); check("R10 count unchanged", r, 32'h0001_0001);

    // R4 broadcast kept by default
    tag = "R4"; mk_frame(BC, 7); expect_frm(32'h110, 32'h1100, 7, 1);
    send_frm(); settle("R4 broadcast kept");

    // R4 broadcast dropped, multicast passes
    reg_wr(4'd5, 32'h0); reg_wr(4'd4, 32'h200);
    tag = "R4"; mk_frame(BC, 8);
    send_frm(); settle("R4 broadcast dropped");
    tag = "R3"; mk_frame(MC, 9); expect_frm(32'h120, 32'h1200, 9, 1);
    send_frm(); settle("R3 multicast pass");

    // R4 keep overrides drop
    reg_wr(4'd4, 32'h300); reg_wr(4'd5, 32'h100);
    tag = "R4"; mk_frame(MC, 11); expect_frm(32'h130, 32'h1300, 11, 1);
    send_frm(); settle("R4 keep override");
    reg_rd(4'd8, r); check("R7 count four", r, 32'h0004_0001);

    // R2 oversize frame stops at the limit
    reg_wr(4'd1, 32'h8);
    tag = "R2"; mk_frame(ME, 12); expect_frm(32'h140, 32'h1400, 8, 0);
    send_frm(); settle("R2 oversize");
    check("R2 size untouched", rd32(32'h144), 32'h8000_0000);
    reg_rd(4'd8, r); check("R2 count unchanged", r, 32'h0004_0001);
    tag = "R2"; mk_frame(ME, 8); expect_frm(32'h140, 32'h1400, 8, 1);
    send_frm(); settle("R2 exact limit");
    reg_wr(4'd1, 32'h600);

    // R5 short frame
    tag = "R5"; mk_frame(ME, 4);
    send_frm(); settle("R5 short frame");

    // R1 receive enable off
    reg_wr(4'd0, 32'h0);
    tag = "R1"; mk_frame(ME, 10);
    send_frm(); settle("R1 rx disabled");
    reg_rd(4'd8, r); check("R1 count unchanged", r, 32'h0005_0001);
    reg_wr(4'd0, 32'h4);

    // R8 descriptor not empty
    tag = "R8"; mk_frame(ME, 10);
    send_frm(); settle("R8 no write");
    reg_rd(4'd8, r); check("R8 overflow flag", r, 32'h0005_0005);
    reg_rd(4'd6, r); check("R8 dma cleared", r, 32'h0);
    tag = "R1"; mk_frame(ME, 10);
    send_frm(); settle("R1 dma off ignored");
    reg_wr(4'd8, 32'h4);
    reg_rd(4'd8, r); check("R8 overflow cleared", r, 32'h0005_0001);

    // R7 acknowledge
    reg_wr(4'd8, 32'h1);
    reg_rd(4'd8, r); check("R7 decrement", r, 32'h0004_0001);
    for (int i = 0; i < 4; i++) reg_wr(4'd8, 32'h1);
    reg_rd(4'd8, r); check("R7 cleared at zero", r, 32'h0);

    // R9 reload from descriptor register
    reg_wr(4'd7, 32'h201);
    reg_wr(4'd6, 32'h1);
    tag = "R9"; mk_frame(ME, 12); expect_frm(32'h200, 32'h2000, 12, 1);
    send_frm(); settle("R9 reload");
    reg_rd(4'd8, r); check("R9 count", r, 32'h0001_0001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule